// File: doc/BRIEF.md
# Sponge Hash Command Sequencer

This block is the top-level controller of a sponge-construction hash engine. Software issues one-hot commands through a 4-bit command field with a write strobe. The sequencer steps through idle, absorb and squeeze phases. It sends single-cycle pulses to the datapath that tell it to begin, to process the prefix or key block, to close the message, and to run an extra permutation while squeezing. The datapath answers each piece of work with a permutation-done pulse.

The sequencer owns the configuration lock. A configuration word is taken in only while idle. Secret-key and prefix writes are passed on only while idle; when they arrive at any other time they are refused and reported. A command given in the wrong phase, a malformed command, or a run command given while a permutation is still working parks the machine in an error state. The machine records a cause code there and leaves only when an acknowledge arrives.

Top module: `hash_cmd_seq`

## Requirements
- R1: After reset the idle status is 1, the absorb and squeeze status bits are 0, every pulse output is 0, the error code is 0, the stored configuration is 0, and the configuration unlock output is 1.
- R2: The legal command values are start = 4'b0001, process = 4'b0010, run = 4'b0100 and done = 4'b1000. Any other value written with the strobe, including zero, moves the machine to the error state with code 1.
- R3: A start command in idle gives a start pulse in the cycle after the strobe and sets the absorb status. When configuration bit 1 (prefixed mode) or bit 0 (keyed mode) is set, the prefix-block pulse is given in that same cycle.
- R4: After the prefix block, a permutation-done moves the machine to the key block when keyed mode is set, with a key-block pulse. Otherwise it moves to message intake. A permutation-done during the key block moves the machine to message intake. When both mode bits are 0, start leads straight to message intake.
- R5: Process is accepted only during message intake. It gives a process pulse. The next permutation-done sets the squeeze status and gives a one-cycle done pulse.
- R6: Run is accepted in squeeze when no permutation is in progress. It gives a run pulse and keeps the squeeze status. A permutation-done makes the machine ready again, so any number of runs may follow.
- R7: A run command while a squeeze permutation is in progress gives error code 3.
- R8: Done is accepted in squeeze when no permutation is in progress. It gives a clear pulse and returns the machine to idle.
- R9: A legal command that the current phase does not accept gives error code 2.
- R10: The configuration write is applied only in idle. The unlock output is 1 only in idle. A configuration write at any other time leaves the stored value unchanged and raises no error.
- R11: The key-write and prefix-write pass-through outputs are 1 only when the matching write arrives in idle. The same write in any other non-error phase is not passed through and gives error code 4.
- R12: In the error state all three status bits are 0. The error pulse lasts one cycle on entry. The code holds and commands and writes are ignored. An acknowledge returns the machine to idle with code 0.
- R13: A permutation-done that arrives while the machine is not waiting for one has no effect.
- R14: When several faults occur in the same cycle, the recorded code is the command fault (1, 2 or 3) rather than the write fault (4).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_i | input | 4 | One-hot command value |
| cmd_we_i | input | 1 | Command write strobe |
| perm_done_i | input | 1 | Datapath finished the current permutation |
| err_ack_i | input | 1 | Leave the error state |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_i | input | CFG_W | Configuration value (bit 0 keyed, bit 1 prefixed) |
| key_we_i | input | 1 | Key register write request |
| prefix_we_i | input | 1 | Prefix register write request |
| cfg_o | output | CFG_W | Stored configuration |
| cfg_unlock_o | output | 1 | Configuration writable |
| key_wr_ok_o | output | 1 | Key write passed through |
| prefix_wr_ok_o | output | 1 | Prefix write passed through |
| st_idle_o | output | 1 | Idle status |
| st_absorb_o | output | 1 | Absorb status |
| st_squeeze_o | output | 1 | Squeeze status |
| start_o | output | 1 | Begin pulse to datapath |
| prefix_blk_o | output | 1 | Process prefix block pulse |
| key_blk_o | output | 1 | Process key block pulse |
| process_o | output | 1 | Close message pulse |
| run_o | output | 1 | Extra permutation pulse |
| clear_o | output | 1 | Clear datapath pulse |
| done_o | output | 1 | Absorb complete event |
| err_o | output | 1 | Error event |
| err_code_o | output | 3 | Error cause (0 none, 1 encoding, 2 order, 3 busy run, 4 busy write) |

## Verification
The hardest situations to create are the waiting phases. These are the prefix block, the key block, the final block and a running squeeze permutation. The machine reaches them only through a chain of accepted commands and withheld permutation-done pulses. For each of the seven reachable phases the bench resets, walks the engine there through the ports, and then writes each of the sixteen command values. It checks status, pulses and error code against a model of which command each phase accepts.

// File: rtl/hash_cmd_seq.sv
module hash_cmd_seq #(
  parameter int CFG_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [3:0]       cmd_i,
  input  logic             cmd_we_i,
  input  logic             perm_done_i,
  input  logic             err_ack_i,
  input  logic             cfg_we_i,
  input  logic [CFG_W-1:0] cfg_i,
  input  logic             key_we_i,
  input  logic             prefix_we_i,
  output logic [CFG_W-1:0] cfg_o,
  output logic             cfg_unlock_o,
  output logic             key_wr_ok_o,
  output logic             prefix_wr_ok_o,
  output logic             st_idle_o,
  output logic             st_absorb_o,
  output logic             st_squeeze_o,
  output logic             start_o,
  output logic             prefix_blk_o,
  output logic             key_blk_o,
  output logic             process_o,
  output logic             run_o,
  output logic             clear_o,
  output logic             done_o,
  output logic             err_o,
  output logic [2:0]       err_code_o
);

  typedef enum logic [2:0] {
    S_IDLE, S_PRE, S_KEY, S_MSG, S_FIN, S_SQZ, S_RUN, S_ERR
  } state_t;

  localparam logic [3:0] C_START = 4'b0001;
  localparam logic [3:0] C_PROC  = 4'b0010;
  localparam logic [3:0] C_RUN   = 4'b0100;
  localparam logic [3:0] C_DONE  = 4'b1000;

  state_t st, nxt;
  logic [CFG_W-1:0] cfg_q;
  logic [2:0] code_q, code_c;
  logic [6:0] pls_q, pls_c;

  wire legal = (cmd_i == C_START) || (cmd_i == C_PROC) ||
               (cmd_i == C_RUN) || (cmd_i == C_DONE);
  wire idle  = (st == S_IDLE);
  wire wr_busy = (key_we_i || prefix_we_i) && !idle;

  always_comb begin
    nxt    = st;
    code_c = 3'd0;
    pls_c  = '0;
    if (st != S_ERR) begin
      if (cmd_we_i) begin
        if (!legal) code_c = 3'd1;
        else begin
          unique case (st)
            S_IDLE: if (cmd_i == C_START) begin
              pls_c[0] = 1'b1;
              if (cfg_q[0] || cfg_q[1]) begin
                nxt = S_PRE;
                pls_c[1] = 1'b1;
              end else nxt = S_MSG;
            end else code_c = 3'd2;
            S_MSG: if (cmd_i == C_PROC) begin
              nxt = S_FIN;
              pls_c[3] = 1'b1;
            end else code_c = 3'd2;
            S_SQZ: if (cmd_i == C_RUN) begin
              nxt = S_RUN;
              pls_c[4] = 1'b1;
            end else if (cmd_i == C_DONE) begin
              nxt = S_IDLE;
              pls_c[5] = 1'b1;
            end else code_c = 3'd2;
            S_RUN: code_c = (cmd_i == C_RUN) ? 3'd3 : 3'd2;
            default: code_c = 3'd2;
          endcase
        end
      end else if (perm_done_i) begin
        unique case (st)
          S_PRE: if (cfg_q[0]) begin
            nxt = S_KEY;
            pls_c[2] = 1'b1;
          end else nxt = S_MSG;
          S_KEY: nxt = S_MSG;
          S_FIN: begin
            nxt = S_SQZ;
            pls_c[6] = 1'b1;
          end
          S_RUN: nxt = S_SQZ;
          default: ;
        endcase
      end
      if (code_c == 3'd0 && wr_busy) code_c = 3'd4;
      if (code_c != 3'd0) begin
        nxt   = S_ERR;
        pls_c = '0;
      end
    end else if (err_ack_i) begin
      nxt = S_IDLE;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st     <= S_IDLE;
      cfg_q  <= '0;
      code_q <= 3'd0;
      pls_q  <= '0;
      err_o  <= 1'b0;
    end else begin
      st    <= nxt;
      pls_q <= pls_c;
      err_o <= (code_c != 3'd0);
      if (cfg_we_i && idle) cfg_q <= cfg_i;
      if (code_c != 3'd0) code_q <= code_c;
      else if (st == S_ERR && err_ack_i) code_q <= 3'd0;
    end
  end

  assign cfg_o          = cfg_q;
  assign cfg_unlock_o   = idle;
  assign key_wr_ok_o    = key_we_i && idle;
  assign prefix_wr_ok_o = prefix_we_i && idle;
  assign st_idle_o      = idle;
  assign st_absorb_o    = (st == S_PRE) || (st == S_KEY) || (st == S_MSG) || (st == S_FIN);
  assign st_squeeze_o   = (st == S_SQZ) || (st == S_RUN);
  assign {done_o, clear_o, run_o, process_o, key_blk_o, prefix_blk_o, start_o} = pls_q;
  assign err_code_o     = code_q;

  // R12
  status_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({st_idle_o, st_absorb_o, st_squeeze_o}));

  // R12
  err_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (st == S_ERR) && (err_code_o != 3'd0));

  // R12
  err_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == S_ERR && !err_ack_i) |=> (st == S_ERR) && $stable(err_code_o));

  // R10
  cfg_lock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !idle |=> $stable(cfg_o));

  // R6
  run_from_sqz_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_o |-> st_squeeze_o && $past(st == S_SQZ));

  // R5
  done_after_fin_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (st == S_SQZ) && $past(st == S_FIN));

endmodule

// File: tb/hash_cmd_seq_tb_top.sv
`timescale 1ns/1ps
module hash_cmd_seq_tb_top;
  logic clk = 1'b0, rst_ni = 1'b0;
  logic [3:0] cmd_i = '0;
  logic cmd_we_i = 0, perm_done_i = 0, err_ack_i = 0, cfg_we_i = 0, key_we_i = 0, prefix_we_i = 0;
  logic [7:0] cfg_i = '0;
  logic [7:0] cfg_o;
  logic cfg_unlock_o, key_wr_ok_o, prefix_wr_ok_o, st_idle_o, st_absorb_o, st_squeeze_o;
  logic start_o, prefix_blk_o, key_blk_o, process_o, run_o, clear_o, done_o, err_o;
  logic [2:0] err_code_o;
  int checks = 0, fails = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  hash_cmd_seq #(.CFG_W(8)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .cmd_i(cmd_i), .cmd_we_i(cmd_we_i),
    .perm_done_i(perm_done_i), .err_ack_i(err_ack_i), .cfg_we_i(cfg_we_i),
    .cfg_i(cfg_i), .key_we_i(key_we_i), .prefix_we_i(prefix_we_i),
    .cfg_o(cfg_o), .cfg_unlock_o(cfg_unlock_o), .key_wr_ok_o(key_wr_ok_o),
    .prefix_wr_ok_o(prefix_wr_ok_o), .st_idle_o(st_idle_o), .st_absorb_o(st_absorb_o),
    .st_squeeze_o(st_squeeze_o), .start_o(start_o), .prefix_blk_o(prefix_blk_o),
    .key_blk_o(key_blk_o), .process_o(process_o), .run_o(run_o), .clear_o(clear_o),
    .done_o(done_o), .err_o(err_o), .err_code_o(err_code_o));

  // {idle, absorb, squeeze, err, code[2:0], start, pre, key, proc, run, clear, done}
  function automatic logic [13:0] obs();
    return {st_idle_o, st_absorb_o, st_squeeze_o, err_o, err_code_o, start_o,
            prefix_blk_o, key_blk_o, process_o, run_o, clear_o, done_o};
  endfunction

  function automatic logic [13:0] mk(int ph, bit e, int code, logic [6:0] p);
    logic [2:0] s;
    s = (ph == 0) ? 3'b100 : (ph == 1) ? 3'b010 : (ph == 2) ? 3'b001 : 3'b000;
    return {s, e, code[2:0], p};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_ni = 0; cmd_we_i = 0; perm_done_i = 0; err_ack_i = 0;
    cfg_we_i = 0; key_we_i = 0; prefix_we_i = 0;
    repeat (2) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
  endtask

  task automatic cmd(logic [3:0] c);
    cmd_i = c; cmd_we_i = 1; @(negedge clk); cmd_we_i = 0;
  endtask

  task automatic pdone();
    perm_done_i = 1; @(negedge clk); perm_done_i = 0;
  endtask

  task automatic wcfg(logic [7:0] v);
    cfg_i = v; cfg_we_i = 1; @(negedge clk); cfg_we_i = 0;
  endtask

  // phases: 0 idle,1 prefix,2 key,3 msg,4 final,5 squeeze,6 squeeze-running
  task automatic reach(int ph);
    do_reset();
    wcfg(8'h03);
    if (ph >= 1) cmd(4'b0001);
    if (ph >= 2) pdone();
    if (ph >= 3) pdone();
    if (ph >= 4) cmd(4'b0010);
    if (ph >= 5) pdone();
    if (ph >= 6) cmd(4'b0100);
  endtask

  initial begin
    // R1
    do_reset();
    chk("R1", {18'd0, obs()}, {18'd0, mk(0, 0, 0, 7'd0)});
    chk("R1", {23'd0, cfg_unlock_o, cfg_o}, {23'd0, 1'b1, 8'h00});

    // sweep: R2 R3 R5 R6 R7 R8 R9
    for (int ph = 0; ph < 7; ph++) begin
      for (int c = 0; c < 16; c++) begin
        bit lg;
        int code, eph;
        logic [6:0] p;
        string rq;
        lg = (c == 1) || (c == 2) || (c == 4) || (c == 8);
        p = 7'd0; eph = 0;
        if (!lg) begin code = 1; rq = "R2"; end
        else if (ph == 0 && c == 1) begin code = 0; rq = "R3"; eph = 1; p = 7'b1100000; end
        else if (ph == 3 && c == 2) begin code = 0; rq = "R5"; eph = 1; p = 7'b0001000; end
        else if (ph == 5 && c == 4) begin code = 0; rq = "R6"; eph = 2; p = 7'b0000100; end
        else if (ph == 5 && c == 8) begin code = 0; rq = "R8"; eph = 0; p = 7'b0000010; end
        else if (ph == 6 && c == 4) begin code = 3; rq = "R7"; end
        else begin code = 2; rq = "R9"; end
        reach(ph);
        cmd(c[3:0]);
        if (code != 0) chk(rq, {18'd0, obs()}, {18'd0, mk(3, 1, code, 7'd0)});
        else chk(rq, {18'd0, obs()}, {18'd0, mk(eph, 0, 0, p)});
      end
    end

    // R5 done event after final block
    reach(4);
    pdone();
    chk("R5", {18'd0, obs()}, {18'd0, mk(2, 0, 0, 7'b0000001)});

    // R4 prefixed only: no key block
    do_reset(); wcfg(8'h02); cmd(4'b0001);
    chk("R4", {18'd0, obs()}, {18'd0, mk(1, 0, 0, 7'b1100000)});
    pdone();
    chk("R4", {18'd0, obs()}, {18'd0, mk(1, 0, 0, 7'd0)});
    cmd(4'b0010);
    chk("R4", {18'd0, obs()}, {18'd0, mk(1, 0, 0, 7'b0001000)});
    // R4 keyed: key block pulse
    reach(1); pdone();
    chk("R4", {18'd0, obs()}, {18'd0, mk(1, 0, 0, 7'b0010000)});
    // R4 plain: straight to message
    do_reset(); cmd(4'b0001);
    chk("R4", {18'd0, obs()}, {18'd0, mk(1, 0, 0, 7'b1000000)});
    cmd(4'b0010);
    chk("R4", {18'd0, obs()}, {18'd0, mk(1, 0, 0, 7'b0001000)});

    // R6 repeated runs
    reach(6); pdone();
    chk("R6", {18'd0, obs()}, {18'd0, mk(2, 0, 0, 7'd0)});
    cmd(4'b0100);
    chk("R6", {18'd0, obs()}, {18'd0, mk(2, 0, 0, 7'b0000100)});

    // R13 stray permutation-done
    reach(3); pdone();
    chk("R13", {18'd0, obs()}, {18'd0, mk(1, 0, 0, 7'd0)});
    cmd(4'b0010);
    chk("R13", {18'd0, obs()}, {18'd0, mk(1, 0, 0, 7'b0001000)});
    do_reset(); pdone();
    chk("R13", {18'd0, obs()}, {18'd0, mk(0, 0, 0, 7'd0)});

    // R10 configuration lock
    reach(3);
    chk("R10", {31'd0, cfg_unlock_o}, 32'd0);
    wcfg(8'hA5);
    chk("R10", {24'd0, cfg_o}, 32'h03);
    chk("R10", {18'd0, obs()}, {18'd0, mk(1, 0, 0, 7'd0)});
    do_reset(); wcfg(8'h5A);
    chk("R10", {23'd0, cfg_unlock_o, cfg_o}, {23'd0, 1'b1, 8'h5A});

    // R11 key/prefix writes
    do_reset();
    key_we_i = 1; #1;
    chk("R11", {31'd0, key_wr_ok_o}, 32'd1);
    key_we_i = 0; prefix_we_i = 1; #1;
    chk("R11", {31'd0, prefix_wr_ok_o}, 32'd1);
    @(negedge clk); prefix_we_i = 0;
    reach(5);
    key_we_i = 1; #1;
    chk("R11", {31'd0, key_wr_ok_o}, 32'd0);
    @(negedge clk); key_we_i = 0;
    chk("R11", {18'd0, obs()}, {18'd0, mk(3, 1, 4, 7'd0)});
    reach(1);
    prefix_we_i = 1; #1;
    chk("R11", {31'd0, prefix_wr_ok_o}, 32'd0);
    @(negedge clk); prefix_we_i = 0;
    chk("R11", {29'd0, err_code_o}, 32'd4);

    // R14 command fault wins over write fault
    reach(3);
    key_we_i = 1; cmd(4'b0011); key_we_i = 0;
    chk("R14", {29'd0, err_code_o}, 32'd1);
    reach(5);
    prefix_we_i = 1; cmd(4'b0001); prefix_we_i = 0;
    chk("R14", {29'd0, err_code_o}, 32'd2);

    // R12 error hold and acknowledge
    reach(6); cmd(4'b0100);
    @(negedge clk);
    chk("R12", {18'd0, obs()}, {18'd0, mk(3, 0, 3, 7'd0)});
    cmd(4'b0001);
    chk("R12", {18'd0, obs()}, {18'd0, mk(3, 0, 3, 7'd0)});
    key_we_i = 1; #1;
    chk("R12", {31'd0, key_wr_ok_o}, 32'd0);
    @(negedge clk); key_we_i = 0;
    err_ack_i = 1; @(negedge clk); err_ack_i = 0;
    chk("R12", {18'd0, obs()}, {18'd0, mk(0, 0, 0, 7'd0)});
    cmd(4'b0001);
    chk("R12", {18'd0, obs()}, {18'd0, mk(1, 0, 0, 7'b1100000)});

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule